// File: doc/BRIEF.md
# Power switch fault-timing sequencer

This block is the digital control sequencer of a protected power switch. Comparators elsewhere already reduce the analog conditions to logic levels. The sequencer reads those levels: an overcurrent, a severe overcurrent at more than twice the set limit, an output-charged indication, a thermal-shutdown indication and a resolved enable. It also reads two mode-select pins. From these it decides when the switch conducts and which current-limit multiplier the analog regulator applies. All timing is measured in pulses of a prescaled `tick` input, and every interval is a parameter given in ticks.

Each power-up and each restart first waits a debounce or restart delay. It then enters a startup phase that runs in continuous mode. For the first part of startup the limit multiplier is raised. When the startup timeout ends, the output must be charged or the switch locks off. At that moment the mode pins are sampled, and they choose latch-off, auto-retry or continuous fault handling until the next startup. Severe overloads and thermal shutdown cut the switch at once. Each has its own recovery path.

Top module: `pwr_switch_seq`

## Requirements
- R1: While `rst_n` is low, and on the clock after `en_ok` is low, `sw_on` is 0 and `ilim_sel` is 0 (1x).
- R2: After `en_ok` rises, the switch stays off for DEB_TICKS ticks and then turns on in the startup phase.
- R3: During the first STI_TICKS ticks of the startup phase, `ilim_sel` equals STARTUP_CODE (0 = 1x, 1 = 1.5x, 2 = 2x). For the rest of startup and afterwards it is 0. It is never nonzero while the switch is off.
- R4: When STO_TICKS ticks of startup have elapsed, the block goes to normal operation if `out_charged` is high. Otherwise the switch locks off, and only a low level on `en_ok` clears the lock.
- R5: `mode_pins` is sampled only at the end of startup: 00 selects latch-off, 01 selects auto-retry, 10 and 11 select continuous. Changes at other times have no effect.
- R6: In latch-off and auto-retry modes, an overcurrent lasting BLANK_TICKS ticks turns the switch off. An overcurrent that clears sooner resets the blanking count, and the switch stays on.
- R7: In auto-retry mode, the switch stays off for 30 x BLANK_TICKS ticks after blanking expires. It then restarts through the startup phase.
- R8: In latch-off mode, the switch stays off after blanking expires until `en_ok` goes low and returns high.
- R9: In continuous mode, `oc` does not turn the switch off.
- R10: `oc_severe` turns the switch off on the next clock. Restart follows after FAST_TICKS ticks free of severe overload. In latch-off mode, a severe overload that persists for BLANK_TICKS ticks locks the switch off.
- R11: `therm_hot` turns the switch off on the next clock. After cool-down, continuous mode restarts after the debounce delay, auto-retry restarts after the retry time, and latch-off stays off until the enable is toggled. Startup counts as continuous.
- R12: Every turn-on passes through the startup phase, so the switch always turns on with the startup multiplier selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Prescaled time-base enable, one pulse per timer step |
| en_ok | input | 1 | Resolved enable level; low also stands for a power cycle |
| oc | input | 1 | Current at or above the set limit |
| oc_severe | input | 1 | Current above twice the set limit |
| out_charged | input | 1 | Output has reached its charged level |
| therm_hot | input | 1 | Die temperature above the shutdown threshold, with hysteresis |
| mode_pins | input | 2 | Fault-response select, sampled at end of startup |
| sw_on | output | 1 | Switch conduct command |
| ilim_sel | output | 2 | Current-limit multiplier code: 0 = 1x, else STARTUP_CODE |

## Verification
The bench builds the block with DEB_TICKS=3, STI_TICKS=4, STO_TICKS=12, BLANK_TICKS=5 (so the retry time is 150 ticks), FAST_TICKS=2 and STARTUP_CODE=2, and it pulses `tick` every third clock. With these values every timed path fits into a few hundred cycles. These paths include the boosted window, the startup timeout, a full auto-retry period, thermal recovery in each mode and a severe overload that outlasts blanking in latch-off mode. A behavioural model is compared against both outputs on every clock, and directed checks confirm the mode-specific outcomes.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    PS_OFF,
    PS_DEB,
    PS_START,
    PS_RUN,
    PS_FAST,
    PS_COOL,
    PS_RETRY,
    PS_LOCK
  } psq_state_e;

  typedef enum logic [1:0] {
    FM_LOCK  = 2'd0,
    FM_RETRY = 2'd1,
    FM_CONT  = 2'd2
  } psq_mode_e;

endpackage

// File: rtl/psq_mode_dec.sv
module psq_mode_dec
  import psq_pkg::*;
(
  input  logic [1:0] pins,
  output psq_mode_e  mode
);

  // High select bit wins: both 1x codes mean continuous, open pins read 1.
  always_comb begin
    if (pins[1])      mode = FM_CONT;
    else if (pins[0]) mode = FM_RETRY;
    else              mode = FM_LOCK;
  end

endmodule

// File: rtl/psq_count.sv
module psq_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  logic [W-1:0] q_n;

  always_comb begin
    if (clr)      q_n = '0;
    else if (inc) q_n = q + W'(1);
    else          q_n = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq
  import psq_pkg::*;
#(
  parameter int DEB_TICKS    = 150,
  parameter int STI_TICKS    = 2400,
  parameter int STO_TICKS    = 120000,
  parameter int BLANK_TICKS  = 2400,
  parameter int FAST_TICKS   = 42,
  parameter int STARTUP_CODE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en_ok,
  input  logic       oc,
  input  logic       oc_severe,
  input  logic       out_charged,
  input  logic       therm_hot,
  input  logic [1:0] mode_pins,
  output logic       sw_on,
  output logic [1:0] ilim_sel
);

  localparam int RETRY_TICKS = 30 * BLANK_TICKS;
  localparam int MAX_A       = (STO_TICKS > RETRY_TICKS) ? STO_TICKS : RETRY_TICKS;
  localparam int MAX_B       = (DEB_TICKS > FAST_TICKS) ? DEB_TICKS : FAST_TICKS;
  localparam int TMAX        = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW          = $clog2(TMAX + 1);
  localparam int BW          = $clog2(BLANK_TICKS + 1);

  localparam logic [TW-1:0] DEB_LAST   = TW'(DEB_TICKS - 1);
  localparam logic [TW-1:0] STO_LAST   = TW'(STO_TICKS - 1);
  localparam logic [TW-1:0] RETRY_LAST = TW'(RETRY_TICKS - 1);
  localparam logic [TW-1:0] FAST_LAST  = TW'(FAST_TICKS - 1);
  localparam logic [TW-1:0] STI_END    = TW'(STI_TICKS);
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_TICKS - 1);
  localparam logic [1:0]    BOOST      = 2'(STARTUP_CODE);

  psq_state_e st_q, st_n;
  psq_mode_e  mode_q, mode_n, pin_mode;
  logic [TW-1:0] tmr_q;
  logic [BW-1:0] blk_q;
  logic tmr_clr, tmr_inc, blk_clr, blk_inc, leave;
  logic deb_done, sto_done, retry_done, fast_done, blank_done;
  logic timed_st;

  psq_mode_dec u_dec (.pins(mode_pins), .mode(pin_mode));

  assign deb_done   = tick && (tmr_q == DEB_LAST);
  assign sto_done   = tick && (tmr_q == STO_LAST);
  assign retry_done = tick && (tmr_q == RETRY_LAST);
  assign fast_done  = tick && !oc_severe && (tmr_q == FAST_LAST);
  assign blank_done = tick && (blk_q == BLANK_LAST);

  // Next-state logic; enable loss overrides everything.
  always_comb begin
    st_n = st_q;
    unique case (st_q)
      PS_OFF:   if (en_ok) st_n = PS_DEB;
      PS_DEB:   if (deb_done) st_n = PS_START;
      PS_START: begin
        if (therm_hot)      st_n = PS_COOL;
        else if (oc_severe) st_n = PS_FAST;
        else if (sto_done)  st_n = out_charged ? PS_RUN : PS_LOCK;
      end
      PS_RUN: begin
        if (therm_hot)
          st_n = (mode_q == FM_LOCK) ? PS_LOCK : PS_COOL;
        else if (oc_severe)
          st_n = PS_FAST;
        else if (oc && blank_done && mode_q != FM_CONT)
          st_n = (mode_q == FM_LOCK) ? PS_LOCK : PS_RETRY;
      end
      PS_FAST: begin
        if (therm_hot)
          st_n = (mode_q == FM_LOCK) ? PS_LOCK : PS_COOL;
        else if (oc_severe && blank_done && mode_q == FM_LOCK)
          st_n = PS_LOCK;
        else if (fast_done)
          st_n = PS_START;
      end
      PS_COOL:  if (!therm_hot) st_n = (mode_q == FM_RETRY) ? PS_RETRY : PS_DEB;
      PS_RETRY: if (retry_done) st_n = PS_START;
      PS_LOCK:  st_n = PS_LOCK;
      default:  st_n = PS_OFF;
    endcase
    if (!en_ok) st_n = PS_OFF;
  end

  assign leave    = (st_n != st_q);
  assign timed_st = (st_q == PS_DEB) || (st_q == PS_START) || (st_q == PS_RETRY);

  // Counter enables: state timer and blanking timer.
  always_comb begin
    tmr_clr = leave || (st_q == PS_FAST && oc_severe)
              || !(timed_st || st_q == PS_FAST);
    tmr_inc = tick && (timed_st || (st_q == PS_FAST && !oc_severe));
    blk_clr = leave || !((st_q == PS_RUN && oc) || (st_q == PS_FAST && oc_severe));
    blk_inc = tick && ((st_q == PS_RUN && mode_q != FM_CONT)
                       || (st_q == PS_FAST && mode_q == FM_LOCK));
  end

  // Startup is forced continuous; the pins take effect only as it ends.
  always_comb begin
    mode_n = mode_q;
    if (leave && st_n == PS_START)                    mode_n = FM_CONT;
    else if (leave && st_q == PS_START && st_n == PS_RUN) mode_n = pin_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_OFF;
      mode_q <= FM_CONT;
    end else begin
      st_q   <= st_n;
      mode_q <= mode_n;
    end
  end

  psq_count #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .q(tmr_q)
  );

  psq_count #(.W(BW)) u_blk (
    .clk(clk), .rst_n(rst_n), .clr(blk_clr), .inc(blk_inc), .q(blk_q)
  );

  assign sw_on    = (st_q == PS_START) || (st_q == PS_RUN);
  assign ilim_sel = (st_q == PS_START && tmr_q < STI_END) ? BOOST : 2'd0;

endmodule

// File: rtl/psq_seq_chk.sv
module psq_seq_chk #(
  parameter int STARTUP_CODE = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_ok,
  input logic       oc_severe,
  input logic       therm_hot,
  input logic       sw_on,
  input logic [1:0] ilim_sel
);

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> !sw_on);

  assert_boost_only_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_sel != 2'd0) |-> (sw_on && ilim_sel == 2'(STARTUP_CODE)));

  assert_severe_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_severe && sw_on) |=> !sw_on);

  assert_thermal_cut_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_hot && sw_on) |=> !sw_on);

  assert_restart_boosted_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_on) |-> (ilim_sel == 2'(STARTUP_CODE)));

endmodule

bind pwr_switch_seq psq_seq_chk #(.STARTUP_CODE(STARTUP_CODE)) u_psq_chk (
  .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .oc_severe(oc_severe),
  .therm_hot(therm_hot), .sw_on(sw_on), .ilim_sel(ilim_sel)
);

// File: tb/tb_pwr_switch_seq.sv
module tb_pwr_switch_seq;

  localparam int DEB = 3, STI = 4, STO = 12, BLK = 5, FST = 2, CODE = 2;
  localparam int RTY = 30 * BLK;
  localparam int WATCHDOG = 150000;

  // model states
  localparam int M_OFF = 0, M_DEB = 1, M_ST = 2, M_RUN = 3, M_FST = 4,
                 M_COOL = 5, M_RTY = 6, M_LCK = 7;
  // model modes
  localparam int K_LCK = 0, K_RTY = 1, K_CNT = 2;

  logic clk = 1'b0;
  logic rst_n, tick, en_ok, oc, oc_severe, out_charged, therm_hot;
  logic [1:0] mode_pins;
  logic sw_on;
  logic [1:0] ilim_sel;

  int checks = 0, errors = 0, cycles = 0, divc = 0;
  string cur_req = "R1";

  int ms, mt, mb, mm;

  always #10 clk = ~clk;

  pwr_switch_seq #(
    .DEB_TICKS(DEB), .STI_TICKS(STI), .STO_TICKS(STO),
    .BLANK_TICKS(BLK), .FAST_TICKS(FST), .STARTUP_CODE(CODE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_ok(en_ok), .oc(oc),
    .oc_severe(oc_severe), .out_charged(out_charged), .therm_hot(therm_hot),
    .mode_pins(mode_pins), .sw_on(sw_on), .ilim_sel(ilim_sel)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  // tick every third clock, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      divc = 0;
      tick <= 1'b0;
    end else begin
      divc = (divc + 1) % 3;
      tick <= (divc == 0);
    end
  end

  // Behavioural reference: interval bookkeeping per requirement.
  always @(posedge clk or negedge rst_n) begin
    int nx;
    if (!rst_n) begin
      ms = M_OFF; mt = 0; mb = 0; mm = K_CNT;
    end else begin
      nx = ms;
      if (ms == M_OFF && en_ok) nx = M_DEB;
      if (ms == M_DEB && tick && mt + 1 == DEB) nx = M_ST;
      if (ms == M_ST) begin
        if (therm_hot) nx = M_COOL;
        else if (oc_severe) nx = M_FST;
        else if (tick && mt + 1 == STO) nx = out_charged ? M_RUN : M_LCK;
      end
      if (ms == M_RUN || ms == M_FST) begin
        if (therm_hot) nx = (mm == K_LCK) ? M_LCK : M_COOL;
        else if (ms == M_RUN && oc_severe) nx = M_FST;
        else if (ms == M_RUN && oc && mm != K_CNT && tick && mb + 1 == BLK)
          nx = (mm == K_LCK) ? M_LCK : M_RTY;
        else if (ms == M_FST && oc_severe && mm == K_LCK && tick && mb + 1 == BLK)
          nx = M_LCK;
        else if (ms == M_FST && !oc_severe && tick && mt + 1 == FST) nx = M_ST;
      end
      if (ms == M_COOL && !therm_hot) nx = (mm == K_RTY) ? M_RTY : M_DEB;
      if (ms == M_RTY && tick && mt + 1 == RTY) nx = M_ST;
      if (!en_ok) nx = M_OFF;

      if (nx != ms) begin
        if (nx == M_ST) mm = K_CNT;
        if (ms == M_ST && nx == M_RUN)
          mm = mode_pins[1] ? K_CNT : (mode_pins[0] ? K_RTY : K_LCK);
        mt = 0; mb = 0;
      end else if (ms == M_DEB || ms == M_ST || ms == M_RTY) begin
        if (tick) mt++;
      end else if (ms == M_RUN) begin
        if (!oc) mb = 0; else if (tick && mm != K_CNT) mb++;
      end else if (ms == M_FST) begin
        if (oc_severe) mt = 0; else if (tick) mt++;
        if (!oc_severe) mb = 0; else if (tick && mm == K_LCK) mb++;
      end
      ms = nx;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, int'(sw_on), (ms == M_ST || ms == M_RUN) ? 1 : 0, "sw_on vs model");
      chk(cur_req, int'(ilim_sel), (ms == M_ST && mt < STI) ? CODE : 0, "ilim_sel vs model");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic retoggle();
    en_ok = 1'b0; w(3); en_ok = 1'b1; w(70);
  endtask

  initial begin
    rst_n = 1'b0; en_ok = 1'b0; oc = 1'b0; oc_severe = 1'b0;
    out_charged = 1'b1; therm_hot = 1'b0; mode_pins = 2'b01;
    w(4);
    chk("R1", int'(sw_on), 0, "off in reset");
    chk("R1", int'(ilim_sel), 0, "1x in reset");
    rst_n = 1'b1;
    w(3);

    cur_req = "R2"; en_ok = 1'b1; w(4);
    chk("R2", int'(sw_on), 0, "off during debounce");
    cur_req = "R3"; w(10);
    chk("R3", int'(sw_on), 1, "on in startup");
    chk("R3", int'(ilim_sel), CODE, "boost early in startup");
    w(20);
    chk("R3", int'(ilim_sel), 0, "1x after boost window");
    cur_req = "R4"; w(30);
    chk("R4", int'(sw_on), 1, "running after charged startup");

    cur_req = "R6";
    oc = 1; w(6); oc = 0; w(3); oc = 1; w(9); oc = 0; w(3);
    chk("R6", int'(sw_on), 1, "short overcurrent tolerated");
    oc = 1; w(30);
    chk("R6", int'(sw_on), 0, "blanking expired");
    oc = 0; cur_req = "R7"; w(400);
    chk("R7", int'(sw_on), 0, "held off during retry");
    w(100);
    chk("R7", int'(sw_on), 1, "retried on");
    w(60);

    cur_req = "R5"; mode_pins = 2'b00;
    oc = 1; w(30); oc = 0;
    chk("R5", int'(sw_on), 0, "retry mode cut");
    w(520);
    chk("R5", int'(sw_on), 1, "late pin change ignored, still retry");
    w(60);
    cur_req = "R8"; oc = 1; w(30); oc = 0;
    chk("R8", int'(sw_on), 0, "latch mode cut");
    w(600);
    chk("R8", int'(sw_on), 0, "stays latched");
    retoggle();
    chk("R8", int'(sw_on), 1, "enable toggle clears latch");

    cur_req = "R10"; oc_severe = 1; w(30);
    chk("R10", int'(sw_on), 0, "persistent severe latches");
    oc_severe = 0; w(100);
    chk("R10", int'(sw_on), 0, "severe latch holds");
    mode_pins = 2'b10; retoggle();

    cur_req = "R9"; oc = 1; w(60);
    chk("R9", int'(sw_on), 1, "continuous ignores overcurrent");
    oc = 0;
    cur_req = "R10"; oc_severe = 1; w(1); oc_severe = 0;
    chk("R10", int'(sw_on), 0, "severe cut next clock");
    cur_req = "R12"; w(10);
    chk("R12", int'(sw_on), 1, "restart after severe");
    chk("R12", int'(ilim_sel), CODE, "restart boosted");
    w(50);

    cur_req = "R11"; therm_hot = 1; w(2);
    chk("R11", int'(sw_on), 0, "thermal cut");
    w(300); therm_hot = 0; w(15);
    chk("R11", int'(sw_on), 1, "continuous thermal recovery after debounce");
    w(50);
    mode_pins = 2'b01; retoggle();
    therm_hot = 1; w(3); therm_hot = 0; w(100);
    chk("R11", int'(sw_on), 0, "retry thermal waits retry time");
    w(450);
    chk("R11", int'(sw_on), 1, "retry thermal recovered");
    w(50);
    mode_pins = 2'b00; retoggle();
    therm_hot = 1; w(3); therm_hot = 0; w(600);
    chk("R11", int'(sw_on), 0, "latch thermal stays off");
    retoggle();
    chk("R11", int'(sw_on), 1, "latch thermal cleared by toggle");

    cur_req = "R4"; out_charged = 0; retoggle();
    chk("R4", int'(sw_on), 0, "startup timeout latch");
    out_charged = 1; w(200);
    chk("R4", int'(sw_on), 0, "charge alone does not clear");
    retoggle();
    chk("R4", int'(sw_on), 1, "toggle clears timeout latch");

    cur_req = "R5"; mode_pins = 2'b11; retoggle();
    oc = 1; w(60);
    chk("R5", int'(sw_on), 1, "code 11 is continuous");
    oc = 0;
    cur_req = "R1"; en_ok = 0; w(2);
    chk("R1", int'(sw_on), 0, "enable low cuts");
    w(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule